// File: doc/BRIEF.md
# Exception Program Counter Register Bank

This block keeps the three exception program counter registers of a hart: the machine-level one, the supervisor-level one and the virtual-supervisor-level one. Software changes a register with a CSR write, given as an address, a write enable and write data. When a trap is taken, the hardware loads the faulting PC into the register that belongs to the trap's target privilege level. The CSR read port is combinational. It shows the registered value of the register that the CSR address selects.

Instruction alignment is enforced on every path into and out of the registers. Bit 0 is always forced to zero. When compressed instructions are disabled, so that only 32-bit instruction alignment exists, bit 1 is forced to zero as well. The faulting PC is only VLEN bits wide, so it is sign-extended to XLEN before the mask is applied.

The supervisor register exists only when supervisor mode is configured. The virtual-supervisor register exists only when both supervisor mode and the hypervisor are configured. An access to a register that is not present raises an illegal-access flag.

Top module: `epc_bank`

## Requirements
- R1: After reset, all three registers read as zero.
- R2: A CSR write with `csr_we_i` high stores `csr_wdata_i` at the next clock edge, with these changes: bit 0 is cleared, and bit 1 is also cleared when `RVC_EN` is 0. The CSR addresses are 0x341 for machine, 0x141 for supervisor and 0x241 for virtual supervisor.
- R3: A trap with `trap_valid_i` high loads the register chosen by `trap_tgt_i` (0 = machine, 1 = supervisor, 2 = virtual supervisor). The stored value is `trap_pc_i` sign-extended from bit VLEN-1 to XLEN, then passed through the same low-bit mask as R2.
- R4: When a trap and a CSR write target the same register in the same cycle, the trap value is stored. A CSR write to a different register in that same cycle is still stored.
- R5: `csr_rdata_o` follows the registered value only. In the cycle of a write it still shows the old value. A register with no write and no trap keeps its value.
- R6: On the read port, bit 0 is always zero, and bits 1:0 are always zero when `RVC_EN` is 0. With `RVC_EN` at 1, bit 1 is returned as stored.
- R7: The supervisor register is absent when `S_EN` is 0. The virtual-supervisor register is absent unless both `S_EN` and `H_EN` are 1. A read or write of an absent register raises `csr_illegal_o` in that cycle, returns zero and changes nothing.
- R8: A trap is ignored when its target register is absent, when `trap_tgt_i` is 3, or when `trap_valid_i` is low.
- R9: An address that matches none of the three registers returns zero, does not raise `csr_illegal_o`, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_addr_i | input | 12 | CSR address, used for both read and write |
| csr_we_i | input | 1 | CSR write enable |
| csr_re_i | input | 1 | CSR read qualifier, used for the illegal-access flag |
| csr_wdata_i | input | XLEN | CSR write data |
| trap_valid_i | input | 1 | Trap entry this cycle |
| trap_tgt_i | input | 2 | Trap target level: 0 machine, 1 supervisor, 2 virtual supervisor |
| trap_pc_i | input | VLEN | Faulting PC |
| csr_rdata_o | output | XLEN | Masked read data |
| csr_illegal_o | output | 1 | Access to a register that is not present |

## Verification
The hardest case to reach is a cycle where the trap path and the CSR write path act together. In one such cycle both paths hit the same register, so the trap must win. In the other, each path hits a different register, and both updates must land. The stimulus table has vectors that drive a CSR write and a trap in the same cycle for each of these two cases. Two instances with different configurations share the stimulus. One has 32-bit alignment with all three registers present. The other allows compressed instructions and has only the machine register. Every vector therefore also exercises the absent-register rules and the bit-1 masking difference.

// File: rtl/epc_pkg.sv
package epc_pkg;

    localparam int unsigned EPC_SLOTS = 3;
    localparam int unsigned CSR_AW    = 12;

    // slot indices; the trap target code equals the slot index
    localparam int unsigned SLOT_M  = 0;
    localparam int unsigned SLOT_S  = 1;
    localparam int unsigned SLOT_VS = 2;

    typedef enum logic [1:0] {
        TGT_M    = 2'd0,
        TGT_S    = 2'd1,
        TGT_VS   = 2'd2,
        TGT_RSVD = 2'd3
    } trap_tgt_e;

    function automatic logic [CSR_AW-1:0] slot_addr(input int unsigned idx);
        case (idx)
            SLOT_M:  return 12'h341;
            SLOT_S:  return 12'h141;
            default: return 12'h241;
        endcase
    endfunction

    function automatic logic [EPC_SLOTS-1:0] slot_present(input bit s_en, input bit h_en);
        return {s_en & h_en, s_en, 1'b1};
    endfunction

endpackage

// File: rtl/epc_align.sv
module epc_align #(
    parameter int unsigned XLEN     = 64,
    parameter bit          IALIGN32 = 1'b0
) (
    input  logic [XLEN-1:0] raw_i,
    output logic [XLEN-1:0] aligned_o
);
    localparam int unsigned CLR = IALIGN32 ? 2 : 1;

    logic unused_low;
    assign unused_low = ^raw_i[CLR-1:0];

    generate
        if (IALIGN32) begin : g_word
            assign aligned_o = {raw_i[XLEN-1:2], 2'b00};
        end else begin : g_half
            assign aligned_o = {raw_i[XLEN-1:1], 1'b0};
        end
    endgenerate
endmodule

// File: rtl/epc_sext.sv
module epc_sext #(
    parameter int unsigned XLEN = 64,
    parameter int unsigned VLEN = 39
) (
    input  logic [VLEN-1:0] pc_i,
    output logic [XLEN-1:0] pc_o
);
    generate
        if (XLEN > VLEN) begin : g_ext
            assign pc_o = {{(XLEN-VLEN){pc_i[VLEN-1]}}, pc_i};
        end else begin : g_same
            assign pc_o = pc_i[XLEN-1:0];
        end
    endgenerate
endmodule

// File: rtl/epc_csr_decode.sv
module epc_csr_decode
    import epc_pkg::*;
#(
    parameter bit S_EN = 1'b1,
    parameter bit H_EN = 1'b1
) (
    input  logic [CSR_AW-1:0]    addr_i,
    input  logic                 we_i,
    input  logic                 re_i,
    output logic [EPC_SLOTS-1:0] sel_o,
    output logic [EPC_SLOTS-1:0] wr_o,
    output logic                 illegal_o
);
    localparam logic [EPC_SLOTS-1:0] PRESENT = slot_present(S_EN, H_EN);

    logic [EPC_SLOTS-1:0] match;

    always_comb begin
        for (int i = 0; i < EPC_SLOTS; i++) begin
            match[i] = (addr_i == slot_addr(i));
        end
        sel_o     = match & PRESENT;
        wr_o      = we_i ? sel_o : '0;
        illegal_o = (we_i | re_i) & (|(match & ~PRESENT));
    end
endmodule

// File: rtl/epc_slot.sv
module epc_slot #(
    parameter int unsigned XLEN     = 64,
    parameter int unsigned VLEN     = 39,
    parameter bit          IALIGN32 = 1'b0
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            wr_en_i,
    input  logic [XLEN-1:0] wr_data_i,
    input  logic            trap_en_i,
    input  logic [VLEN-1:0] trap_pc_i,
    output logic [XLEN-1:0] epc_o
);
    typedef struct packed {
        logic [XLEN-1:0] epc;
    } slot_state_t;

    slot_state_t     state_d, state_q;
    logic [XLEN-1:0] trap_ext;
    logic [XLEN-1:0] raw_next;
    logic [XLEN-1:0] masked_next;

    epc_sext #(.XLEN(XLEN), .VLEN(VLEN)) sext_i (
        .pc_i (trap_pc_i),
        .pc_o (trap_ext)
    );

    // trap entry takes priority over a software write
    always_comb begin
        if (trap_en_i) begin
            raw_next = trap_ext;
        end else begin
            raw_next = wr_data_i;
        end
    end

    epc_align #(.XLEN(XLEN), .IALIGN32(IALIGN32)) wmask_i (
        .raw_i     (raw_next),
        .aligned_o (masked_next)
    );

    always_comb begin
        state_d = state_q;
        if (trap_en_i || wr_en_i) begin
            state_d.epc = masked_next;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign epc_o = state_q.epc;

    AST_TRAP_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_en_i |=> epc_o[VLEN-1:2] == $past(trap_pc_i[VLEN-1:2])); // R3
    AST_TRAP_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_en_i |=> epc_o[XLEN-1] == $past(trap_pc_i[VLEN-1])); // R3
    AST_TRAP_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trap_en_i && wr_en_i) |=> epc_o[VLEN-1:2] == $past(trap_pc_i[VLEN-1:2])); // R4
    AST_WRITE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !trap_en_i) |=> epc_o[XLEN-1:2] == $past(wr_data_i[XLEN-1:2])); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wr_en_i && !trap_en_i) |=> $stable(epc_o)); // R5
endmodule

// File: rtl/epc_bank.sv
module epc_bank
    import epc_pkg::*;
#(
    parameter int unsigned XLEN   = 64,
    parameter int unsigned VLEN   = 39,
    parameter bit          RVC_EN = 1'b1,
    parameter bit          S_EN   = 1'b1,
    parameter bit          H_EN   = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CSR_AW-1:0] csr_addr_i,
    input  logic              csr_we_i,
    input  logic              csr_re_i,
    input  logic [XLEN-1:0]   csr_wdata_i,
    input  logic              trap_valid_i,
    input  logic [1:0]        trap_tgt_i,
    input  logic [VLEN-1:0]   trap_pc_i,
    output logic [XLEN-1:0]   csr_rdata_o,
    output logic              csr_illegal_o
);
    localparam bit                   IALIGN32 = !RVC_EN;
    localparam logic [EPC_SLOTS-1:0] PRESENT  = slot_present(S_EN, H_EN);

    logic [EPC_SLOTS-1:0] rd_sel;
    logic [EPC_SLOTS-1:0] wr_sel;
    logic [EPC_SLOTS-1:0] trap_sel;
    logic [XLEN-1:0]      slot_val [EPC_SLOTS];
    logic [XLEN-1:0]      rd_raw;

    epc_csr_decode #(.S_EN(S_EN), .H_EN(H_EN)) decode_i (
        .addr_i    (csr_addr_i),
        .we_i      (csr_we_i),
        .re_i      (csr_re_i),
        .sel_o     (rd_sel),
        .wr_o      (wr_sel),
        .illegal_o (csr_illegal_o)
    );

    always_comb begin
        for (int i = 0; i < EPC_SLOTS; i++) begin
            trap_sel[i] = trap_valid_i && (trap_tgt_i == 2'(i)) && PRESENT[i];
        end
    end

    generate
        for (genvar g = 0; g < EPC_SLOTS; g++) begin : g_slot
            if (PRESENT[g]) begin : g_on
                epc_slot #(.XLEN(XLEN), .VLEN(VLEN), .IALIGN32(IALIGN32)) slot_i (
                    .clk_i     (clk_i),
                    .rst_ni    (rst_ni),
                    .wr_en_i   (wr_sel[g]),
                    .wr_data_i (csr_wdata_i),
                    .trap_en_i (trap_sel[g]),
                    .trap_pc_i (trap_pc_i),
                    .epc_o     (slot_val[g])
                );
            end else begin : g_off
                logic unused_sel;
                assign unused_sel  = ^{wr_sel[g], trap_sel[g], rd_sel[g]};
                assign slot_val[g] = '0;
            end
        end
    endgenerate

    always_comb begin
        rd_raw = '0;
        for (int i = 0; i < EPC_SLOTS; i++) begin
            if (rd_sel[i]) begin
                rd_raw = rd_raw | slot_val[i];
            end
        end
    end

    epc_align #(.XLEN(XLEN), .IALIGN32(IALIGN32)) rmask_i (
        .raw_i     (rd_raw),
        .aligned_o (csr_rdata_o)
    );

    AST_RD_BIT0_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        csr_rdata_o[0] == 1'b0); // R6
    AST_ILLEGAL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        csr_illegal_o |-> csr_rdata_o == '0); // R7
    AST_TRAP_ONE_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(trap_sel)); // R3

    generate
        if (IALIGN32) begin : g_chk_word
            AST_RD_WORD_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
                csr_rdata_o[1:0] == 2'b00); // R6
        end
    endgenerate
endmodule

// File: tb/epc_bank_tb.sv
module epc_bank_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int XL = 64;
    localparam int VL = 39;
    localparam logic [11:0] AD_M  = 12'h341;
    localparam logic [11:0] AD_S  = 12'h141;
    localparam logic [11:0] AD_VS = 12'h241;

    typedef struct packed {
        logic [11:0]   addr;
        logic          we;
        logic [XL-1:0] wdata;
        logic          tv;
        logic [1:0]    tgt;
        logic [VL-1:0] tpc;
        logic [11:0]   chk;
        logic [XL-1:0] exp;
        logic [15:0]   req;
    } vec_t;

    // expected column is for dut_i (32-bit alignment, all registers present)
    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{AD_M,   1'b1, 64'h0000_0000_8000_0003, 1'b0, 2'd0, 39'h0,            AD_M,  64'h0000_0000_8000_0000, "R2"},
        '{AD_S,   1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 2'd0, 39'h0,            AD_S,  64'hFFFF_FFFF_FFFF_FFFC, "R2"},
        '{AD_M,   1'b0, 64'h0,                   1'b1, 2'd1, 39'h40_0000_0006, AD_S,  64'hFFFF_FFC0_0000_0004, "R3"},
        '{AD_M,   1'b0, 64'h0,                   1'b1, 2'd2, 39'h00_1234_5673, AD_VS, 64'h0000_0000_1234_5670, "R3"},
        '{AD_M,   1'b0, 64'h0,                   1'b1, 2'd0, 39'h7F_FFFF_FFFE, AD_M,  64'hFFFF_FFFF_FFFF_FFFC, "R3"},
        '{AD_M,   1'b1, 64'h0000_0000_0000_0ABC, 1'b1, 2'd0, 39'h100,          AD_M,  64'h0000_0000_0000_0100, "R4"},
        '{AD_S,   1'b1, 64'h0000_0000_0000_5555, 1'b1, 2'd2, 39'h200,          AD_S,  64'h0000_0000_0000_5554, "R4"},
        '{12'h340,1'b1, 64'h0000_0000_0000_00FF, 1'b0, 2'd0, 39'h0,            AD_M,  64'h0000_0000_0000_0100, "R9"},
        '{AD_M,   1'b0, 64'h0,                   1'b1, 2'd3, 39'h777,          AD_M,  64'h0000_0000_0000_0100, "R8"},
        '{AD_M,   1'b0, 64'h0,                   1'b0, 2'd0, 39'h999,          AD_M,  64'h0000_0000_0000_0100, "R8"},
        '{AD_VS,  1'b1, 64'h0000_0001_0000_0002, 1'b0, 2'd0, 39'h0,            AD_VS, 64'h0000_0001_0000_0000, "R2"}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [11:0]   addr = '0;
    logic          we = 1'b0;
    logic          re = 1'b0;
    logic [XL-1:0] wdata = '0;
    logic          tv = 1'b0;
    logic [1:0]    tgt = '0;
    logic [VL-1:0] tpc = '0;
    logic [XL-1:0] rdata_a, rdata_b;
    logic          ill_a, ill_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model state: [0] = dut_i, [1] = dut_c_i
    logic [XL-1:0] mdl [2][3];
    localparam logic [2:0] PRES [2] = '{3'b111, 3'b001};
    localparam bit         RVC  [2] = '{1'b0, 1'b1};

    always #(CLK_PERIOD/2) clk = ~clk;

    epc_bank #(.XLEN(XL), .VLEN(VL), .RVC_EN(1'b0), .S_EN(1'b1), .H_EN(1'b1)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .csr_addr_i(addr), .csr_we_i(we), .csr_re_i(re),
        .csr_wdata_i(wdata), .trap_valid_i(tv), .trap_tgt_i(tgt), .trap_pc_i(tpc),
        .csr_rdata_o(rdata_a), .csr_illegal_o(ill_a)
    );

    epc_bank #(.XLEN(XL), .VLEN(VL), .RVC_EN(1'b1), .S_EN(1'b0), .H_EN(1'b0)) dut_c_i (
        .clk_i(clk), .rst_ni(rst_n), .csr_addr_i(addr), .csr_we_i(we), .csr_re_i(re),
        .csr_wdata_i(wdata), .trap_valid_i(tv), .trap_tgt_i(tgt), .trap_pc_i(tpc),
        .csr_rdata_o(rdata_b), .csr_illegal_o(ill_b)
    );

    function automatic logic [11:0] addr_of(input int i);
        return (i == 0) ? AD_M : (i == 1) ? AD_S : AD_VS;
    endfunction

    function automatic logic [XL-1:0] amask(input logic [XL-1:0] v, input bit rvc);
        return rvc ? {v[XL-1:1], 1'b0} : {v[XL-1:2], 2'b00};
    endfunction

    function automatic logic [XL-1:0] sext(input logic [VL-1:0] p);
        return {{(XL-VL){p[VL-1]}}, p};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [XL-1:0] act, input logic [XL-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic model_step(input vec_t v);
        for (int d = 0; d < 2; d++) begin
            for (int i = 0; i < 3; i++) begin
                if (PRES[d][i]) begin
                    if (v.tv && v.tgt == 2'(i)) begin
                        mdl[d][i] = amask(sext(v.tpc), RVC[d]);
                    end else if (v.we && v.addr == addr_of(i)) begin
                        mdl[d][i] = amask(v.wdata, RVC[d]);
                    end
                end
            end
        end
    endtask

    // read every register on both instances and compare with the model
    task automatic read_all(input string req);
        for (int i = 0; i < 3; i++) begin
            addr = addr_of(i);
            re   = 1'b1;
            #1;
            check(req, $sformatf("dut_i rdata @%h", addr_of(i)), rdata_a, mdl[0][i]);
            check("R7", $sformatf("dut_i illegal @%h", addr_of(i)), {63'b0, ill_a}, {63'b0, !PRES[0][i]});
            check(req, $sformatf("dut_c_i rdata @%h", addr_of(i)), rdata_b, PRES[1][i] ? mdl[1][i] : '0);
            check("R7", $sformatf("dut_c_i illegal @%h", addr_of(i)), {63'b0, ill_b}, {63'b0, !PRES[1][i]});
        end
        re = 1'b0;
    endtask

    task automatic apply(input vec_t v);
        logic absent_b;
        @(negedge clk);
        addr = v.addr; we = v.we; wdata = v.wdata;
        tv = v.tv; tgt = v.tgt; tpc = v.tpc; re = 1'b0;
        #1;
        absent_b = v.we && (v.addr == AD_S || v.addr == AD_VS);
        check("R7", "dut_c_i write-cycle illegal", {63'b0, ill_b}, {63'b0, absent_b});
        check("R9", "dut_i write-cycle illegal", {63'b0, ill_a}, 64'h0);
        @(posedge clk);
        #1;
        we = 1'b0; tv = 1'b0;
        model_step(v);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int d = 0; d < 2; d++) begin
            for (int i = 0; i < 3; i++) mdl[d][i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        read_all("R1");

        // table walk
        for (int k = 0; k < NV; k++) begin
            apply(VECS[k]);
            addr = VECS[k].chk;
            re = 1'b1;
            #1;
            check(string'(VECS[k].req), $sformatf("vector %0d table value", k), rdata_a, VECS[k].exp);
            re = 1'b0;
            read_all(string'(VECS[k].req));
        end

        // R6: with compressed enabled, bit 1 survives on the read port
        addr = AD_M; re = 1'b1; #1;
        check("R6", "dut_c_i keeps bit 1", {63'b0, rdata_b[1]}, {63'b0, 1'b0});
        re = 1'b0;
        apply('{AD_M, 1'b1, 64'h0000_0000_0000_0007, 1'b0, 2'd0, 39'h0, AD_M, 64'h0, "R6"});
        addr = AD_M; re = 1'b1; #1;
        check("R6", "dut_c_i read bit 1 set", rdata_b, 64'h6);
        check("R6", "dut_i read low bits clear", rdata_a, 64'h4);
        re = 1'b0;

        // R5: read in the write cycle shows the old value
        @(negedge clk);
        addr = AD_M; we = 1'b1; wdata = 64'h0000_0000_0000_1230; re = 1'b1;
        #1;
        check("R5", "dut_i read before edge", rdata_a, 64'h4);
        check("R5", "dut_c_i read before edge", rdata_b, 64'h6);
        @(posedge clk);
        #1;
        we = 1'b0;
        #1;
        check("R5", "dut_i read after edge", rdata_a, 64'h1230);
        mdl[0][0] = 64'h1230; mdl[1][0] = 64'h1230;
        re = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        read_all("R5");

        // R1: reset again clears everything
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        rst_n = 1'b1;
        for (int d = 0; d < 2; d++) begin
            for (int i = 0; i < 3; i++) mdl[d][i] = '0;
        end
        read_all("R1");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule